// File: doc/BRIEF.md
# Multi-Lane Second-Tick Aligner

This block takes a set of word-serial lanes that carry the same packet sequence but reach the chip with different delays. It lines them up on a common packet boundary. Every packet opens with a fixed header word. A per-word flag marks the packet that starts each second. Each lane writes into its own small FIFO. The controller throws away the words ahead of the first marker on each lane and holds every lane as soon as its marker reaches the FIFO head. Once all lanes hold a marker, it releases them together, so that word k of every lane leaves in the same cycle on one wide output.

The lanes may be skewed against each other by a bounded number of packets. If the spread is larger, or if a lane FIFO overflows, the block cannot tell how the lanes relate in time. It raises a one-cycle failure flag, empties every FIFO and searches again on the next marker. It does the same when, after it has locked, a later tick packet falls in different slots on different lanes. No word from a slot that disagrees ever reaches the output.

Top module: `tka_tick_aligner`

## Requirements
- R1: After reset, `aligned`, `out_valid` and `align_fail` are all 0.
- R2: A marker is a word with `in_sop`=1, `in_tick`=1 and data equal to the header 0x0800. Words that a lane receives before its first marker are dropped. The word that follows a released marker belongs to that tick packet: with the bench pattern this is the packet index that the tick was placed on, at word position 1.
- R3: Once every lane holds a marker at its FIFO head, the block releases all lanes in lockstep. The first output word after locking is the marker slot (`out_sop`=1, `out_tick`=1). In every output word, lane L sits at bits [L*WORD_W +: WORD_W], and all lanes carry the same slot of the same packet.
- R4: A skew of up to SKEW_PKTS packets (default 8) between the earliest and the latest lane, on lanes that stream without gaps, is absorbed with no failure.
- R5: While waiting for markers, if any lane holds more than (SKEW_PKTS+1)*PKT_WORDS words, the block flags a failure and nothing is output.
- R6: A write into a full lane FIFO (depth (2*SKEW_PKTS+1)*PKT_WORDS words) flags a failure in any state.
- R7: While locked, if a slot's heads disagree across lanes (start-of-packet, tick or header), the block flags a failure and outputs no word of that slot or of any later slot until it relocks.
- R8: `align_fail` is high for exactly one cycle. The FIFOs are then emptied and the block relocks on the next marker common to all lanes.
- R9: A start-of-packet word with the tick flag set but a data value other than 0x0800 does not count as a marker.
- R10: `out_valid` is high only while `aligned` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_LANES | Per-lane word valid |
| in_sop | input | NUM_LANES | Per-lane start-of-packet flag |
| in_tick | input | NUM_LANES | Per-lane second-tick flag, meaningful with in_sop |
| in_data | input | NUM_LANES*WORD_W | Per-lane data words, lane L at [L*WORD_W +: WORD_W] |
| out_valid | output | 1 | Aligned word present |
| out_sop | output | 1 | Output slot is a packet start |
| out_tick | output | 1 | Output slot is the tick marker |
| out_data | output | NUM_LANES*WORD_W | Aligned words of all lanes |
| aligned | output | 1 | Lanes are locked |
| align_fail | output | 1 | One-cycle alignment failure pulse |

## Verification
The bench places the skew right at the limit (8 packets) and one packet past it (36 words). A window check that is off by a packet would then either lock on lanes it cannot resolve or reject a legal spread. It moves one lane's tick a packet late after lock. A design that compared only start-of-packet flags would pass that slot through unaligned. It plants a bad header on a tick word. A design that trusted the flag alone would lock on a corrupt packet. Finally, it stalls one lane for longer than the FIFO depth. A FIFO that wrapped silently would go on releasing shifted data without raising the failure flag.

// File: rtl/tka_pkg.sv
package tka_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_WAIT    = 2'd1,
    ST_ALIGNED = 2'd2,
    ST_FAIL    = 2'd3
  } tka_state_e;

  // Words a lane may hold while others are still missing their marker.
  function automatic int skew_limit_words(input int skew_pkts, input int pkt_words);
    return (skew_pkts + 1) * pkt_words;
  endfunction

  // Physical lane FIFO depth: both skew directions plus one packet of margin.
  function automatic int fifo_depth_words(input int skew_pkts, input int pkt_words);
    return (2 * skew_pkts + 1) * pkt_words;
  endfunction

endpackage

// File: rtl/tka_lane_fifo.sv
module tka_lane_fifo #(
  parameter int EW    = 18,
  parameter int DEPTH = 68,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [EW-1:0] wr_entry,
  input  logic          rd,
  output logic [EW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] cnt,
  output logic          ovf_evt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, rd_ok, wr_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign rd_ok   = rd && !empty;
  assign wr_ok   = wr && (!full || rd_ok);
  assign ovf_evt = wr && full && !rd_ok && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= ptr_next(wp);
      if (rd_ok) rp <= ptr_next(rp);
      cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !flush) mem[wp] <= wr_entry;
  end

  // The controller must never pop a lane that holds nothing (R3 lockstep release).
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty);

  // Occupancy stays inside the physical depth (R6).
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/tka_align_ctrl.sv
module tka_align_ctrl
  import tka_pkg::*;
#(
  parameter int N     = 12,
  parameter int CW    = 7,
  parameter int LIMIT = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         empty,
  input  logic [N-1:0]         h_sop,
  input  logic [N-1:0]         h_tick,
  input  logic [N-1:0]         h_hdr,
  input  logic [N-1:0][CW-1:0] cnt,
  input  logic [N-1:0]         ovf,
  output logic [N-1:0]         pop,
  output logic                 flush,
  output logic                 emit,
  output tka_state_e           state
);
  tka_state_e   state_d;
  logic [N-1:0] marker, over;
  logic         all_marker, any_marker, all_avail, slot_ok;
  logic         sop_all, sop_none, tick_same, hdr_all;

  always_comb begin
    for (int l = 0; l < N; l++) begin
      marker[l] = !empty[l] && h_sop[l] && h_tick[l] && h_hdr[l];
      over[l]   = cnt[l] > CW'(LIMIT);
    end
  end

  assign all_marker = &marker;
  assign any_marker = |marker;
  assign all_avail  = ~|empty;
  assign sop_all    = &h_sop;
  assign sop_none   = ~|h_sop;
  assign tick_same  = (&h_tick) || (~|h_tick);
  assign hdr_all    = &h_hdr;
  assign slot_ok    = sop_none || (sop_all && tick_same && hdr_all);

  assign emit  = (state == ST_ALIGNED) && all_avail && slot_ok;
  assign flush = (state == ST_FAIL);

  always_comb begin
    pop = '0;
    if (state == ST_SEARCH || state == ST_WAIT) pop = ~empty & ~marker;
    else if (emit)                              pop = '1;
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_SEARCH: begin
        if (|ovf)           state_d = ST_FAIL;
        else if (any_marker) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if ((|ovf) || (|over)) state_d = ST_FAIL;
        else if (all_marker)   state_d = ST_ALIGNED;
      end
      ST_ALIGNED: begin
        if (|ovf)                       state_d = ST_FAIL;
        else if (all_avail && !slot_ok) state_d = ST_FAIL;
      end
      ST_FAIL: state_d = ST_SEARCH;
      default: state_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SEARCH;
    else        state <= state_d;
  end

  assert_skew_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && (|over)) |=> state == ST_FAIL);

  assert_overflow_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf) |=> state == ST_FAIL);

  assert_slot_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALIGNED && all_avail && !slot_ok) |=> state == ST_FAIL);

  assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FAIL |=> state == ST_SEARCH);

endmodule

// File: rtl/tka_tick_aligner.sv
module tka_tick_aligner
  import tka_pkg::*;
#(
  parameter int                NUM_LANES = 12,
  parameter int                WORD_W    = 16,
  parameter int                PKT_WORDS = 4,
  parameter int                SKEW_PKTS = 8,
  parameter logic [WORD_W-1:0] HDR_WORD  = 16'h0800
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LANES-1:0]          in_valid,
  input  logic [NUM_LANES-1:0]          in_sop,
  input  logic [NUM_LANES-1:0]          in_tick,
  input  logic [NUM_LANES*WORD_W-1:0]   in_data,
  output logic                          out_valid,
  output logic                          out_sop,
  output logic                          out_tick,
  output logic [NUM_LANES*WORD_W-1:0]   out_data,
  output logic                          aligned,
  output logic                          align_fail
);
  localparam int DEPTH = fifo_depth_words(SKEW_PKTS, PKT_WORDS);
  localparam int LIMIT = skew_limit_words(SKEW_PKTS, PKT_WORDS);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int EW    = WORD_W + 2;

  logic [NUM_LANES-1:0]             pop, empty, ovf, h_sop, h_tick, h_hdr;
  logic [NUM_LANES-1:0][CW-1:0]     cnt;
  logic [NUM_LANES-1:0][WORD_W-1:0] h_data;
  logic                             flush, emit;
  tka_state_e                       state;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [EW-1:0] head;

    tka_lane_fifo #(.EW(EW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr       (in_valid[l]),
      .wr_entry ({in_tick[l] & in_sop[l], in_sop[l], in_data[l*WORD_W +: WORD_W]}),
      .rd       (pop[l]),
      .head     (head),
      .empty    (empty[l]),
      .cnt      (cnt[l]),
      .ovf_evt  (ovf[l])
    );

    assign h_tick[l] = head[EW-1];
    assign h_sop[l]  = head[EW-2];
    assign h_data[l] = head[WORD_W-1:0];
    assign h_hdr[l]  = (head[WORD_W-1:0] == HDR_WORD);
  end

  tka_align_ctrl #(.N(NUM_LANES), .CW(CW), .LIMIT(LIMIT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .empty  (empty),
    .h_sop  (h_sop),
    .h_tick (h_tick),
    .h_hdr  (h_hdr),
    .cnt    (cnt),
    .ovf    (ovf),
    .pop    (pop),
    .flush  (flush),
    .emit   (emit),
    .state  (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_tick  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_sop  <= h_sop[0];
        out_tick <= h_sop[0] & h_tick[0];
        out_data <= h_data;
      end
    end
  end

  assign aligned    = (state == ST_ALIGNED);
  assign align_fail = (state == ST_FAIL);

  assert_out_when_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> aligned);

  assert_fail_drops_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    align_fail |=> !aligned && !out_valid);

endmodule

// File: tb/tb_tka_tick_aligner.sv
`timescale 1ns/1ps
module tb_tka_tick_aligner;
  localparam int NL  = 12;
  localparam int W   = 16;
  localparam int PER = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   in_valid = '0, in_sop = '0, in_tick = '0;
  logic [NL*W-1:0] in_data = '0;
  logic            out_valid, out_sop, out_tick, aligned, align_fail;
  logic [NL*W-1:0] out_data;

  always #2 clk = ~clk;

  tka_tick_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_tick(in_tick), .in_data(in_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_tick(out_tick), .out_data(out_data),
    .aligned(aligned), .align_fail(align_fail)
  );

  int n_vec = 0, n_bad = 0;
  int delay [NL];
  int widx  [NL];
  int bad_lane, bad_pkt, shift_lane, shift_pkt, stall_lane, stall_from, stall_to;
  int scen_cyc, win_lo, win_hi;
  int n_out, first_marker_p, resync_p, first_fail_cyc;
  bit saw_fail, need_marker, after_fail, prev_marker, prev_fail;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit lane_tick(input int l, input int p);
    if (l == shift_lane && p == shift_pkt)     return 1'b0;
    if (l == shift_lane && p == shift_pkt + 1) return 1'b1;
    return (p % PER) == 0;
  endfunction

  task automatic setup(input int start_p);
    rst_n = 1'b0;
    in_valid = '0; in_sop = '0; in_tick = '0; in_data = '0;
    for (int l = 0; l < NL; l++) begin delay[l] = 0; widx[l] = start_p * 4; end
    bad_lane = -1; bad_pkt = -1; shift_lane = -1; shift_pkt = -1;
    stall_lane = -1; stall_from = 0; stall_to = 0;
    win_lo = -1; win_hi = -1; scen_cyc = 0;
    n_out = 0; first_marker_p = -1; resync_p = -1; first_fail_cyc = -1;
    saw_fail = 0; need_marker = 1; after_fail = 0; prev_marker = 0; prev_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      scen_cyc = c;
      for (int l = 0; l < NL; l++) begin
        bit act;
        act = (c >= delay[l]) && !(l == stall_lane && c >= stall_from && c < stall_to);
        if (act) begin
          int w, p, wi;
          w = widx[l]; p = w / 4; wi = w % 4;
          widx[l] = widx[l] + 1;
          in_valid[l] = 1'b1;
          in_sop[l]   = (wi == 0);
          in_tick[l]  = (wi == 0) && lane_tick(l, p);
          if (wi == 0)
            in_data[l*W +: W] = (l == bad_lane && p == bad_pkt) ? 16'h0801 : 16'h0800;
          else
            in_data[l*W +: W] = {4'(l), 8'(p), 4'(wi)};
        end else begin
          in_valid[l] = 1'b0; in_sop[l] = 1'b0; in_tick[l] = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = '0;
    repeat (4) @(negedge clk);
  endtask

  // Output monitor: per-word lockstep, marker ordering, fail pulse width.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_fail) chk(!align_fail, "R8", "fail pulse longer than one cycle", int'(align_fail), 0);
      if (align_fail) begin
        saw_fail = 1; need_marker = 1; after_fail = 1;
        if (first_fail_cyc < 0) first_fail_cyc = scen_cyc;
      end
      prev_fail = align_fail;
      if (out_valid) begin
        logic [W-1:0] w0;
        bit ok;
        n_out++;
        w0 = out_data[W-1:0];
        chk(aligned, "R10", "out_valid without aligned", int'(aligned), 1);
        ok = 1;
        for (int l = 0; l < NL; l++) begin
          logic [W-1:0] wl;
          wl = out_data[l*W +: W];
          if (out_sop) ok = ok && (wl == 16'h0800);
          else         ok = ok && (wl[15:12] == 4'(l)) && (wl[11:0] == w0[11:0]);
        end
        chk(ok, "R3", "lanes out of lockstep (lane0 word)", int'(w0), 0);
        if (need_marker) begin
          chk(out_sop && out_tick, "R3", "first word after lock not marker", int'({out_sop, out_tick}), 3);
          need_marker = 0;
        end
        if (!out_sop) begin
          int p;
          p = int'(w0[11:4]);
          if (prev_marker) begin
            chk((p % PER == 0) && (w0[3:0] == 4'd1), "R2", "word after marker", int'(w0[11:0]), (p / PER) * PER * 16 + 1);
            if (first_marker_p < 0) first_marker_p = p;
            if (after_fail) begin resync_p = p; after_fail = 0; end
          end
          if (p >= win_lo && p <= win_hi) chk(0, "R7", "word of a rejected slot released", p, -1);
        end
        prev_marker = out_sop && out_tick;
      end
    end
  end

  task automatic t_reset;
    setup(0);
    @(negedge clk);
    chk(!aligned,    "R1", "aligned after reset",    int'(aligned), 0);
    chk(!out_valid,  "R1", "out_valid after reset",  int'(out_valid), 0);
    chk(!align_fail, "R1", "align_fail after reset", int'(align_fail), 0);
  endtask

  task automatic t_no_skew;
    setup(5);
    drive(200);
    chk(first_marker_p == 16, "R2", "first released tick packet", first_marker_p, 16);
    chk(!saw_fail, "R4", "fail with zero skew", int'(saw_fail), 0);
    chk(n_out > 100, "R3", "released word count", n_out, 101);
  endtask

  task automatic t_skew_ok;
    setup(5);
    for (int l = 0; l < NL; l++) delay[l] = (l * 32) / (NL - 1);
    drive(300);
    chk(!saw_fail, "R4", "fail at 8-packet skew", int'(saw_fail), 0);
    chk(first_marker_p == 16, "R4", "first tick packet at 8-packet skew", first_marker_p, 16);
    chk(n_out > 150, "R4", "released word count at 8-packet skew", n_out, 151);
  endtask

  task automatic t_skew_bad;
    setup(5);
    delay[NL-1] = 36;
    drive(300);
    chk(saw_fail, "R5", "no fail at 9-packet skew", int'(saw_fail), 1);
    chk(n_out == 0, "R5", "words released at 9-packet skew", n_out, 0);
  endtask

  task automatic t_bad_header;
    setup(0);
    bad_lane = 5; bad_pkt = 0;
    drive(200);
    chk(saw_fail, "R9", "corrupt header accepted as marker", int'(saw_fail), 1);
    chk(first_marker_p == 16, "R9", "first lock packet", first_marker_p, 16);
    chk(aligned, "R8", "not relocked after fail", int'(aligned), 1);
  endtask

  task automatic t_tick_slip;
    setup(0);
    for (int l = 0; l < NL; l++) delay[l] = l;
    shift_lane = 7; shift_pkt = 16;
    win_lo = 16; win_hi = 31;
    drive(400);
    chk(saw_fail, "R7", "tick slot mismatch not flagged", int'(saw_fail), 1);
    chk(resync_p == 32, "R8", "relock packet after fail", resync_p, 32);
    chk(aligned, "R8", "aligned at end", int'(aligned), 1);
  endtask

  task automatic t_stall;
    setup(0);
    stall_lane = 3; stall_from = 150; stall_to = 250;
    drive(260);
    chk(n_out > 80, "R6", "words released before stall", n_out, 81);
    chk(first_fail_cyc >= 200 && first_fail_cyc <= 240, "R6", "overflow fail cycle", first_fail_cyc, 218);
  endtask

  initial begin
    #(4ns * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_skew();
    t_skew_ok();
    t_skew_bad();
    t_bad_header();
    t_tick_slip();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule